// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small microcontroller keep running while the device sleeps. Software arms sleep with an enable bit and fires a one-cycle strobe carrying a 3-bit mode code. The block then turns off the clock-enable of every domain that the chosen mode does not keep alive. The domains are the CPU, data memory with core peripherals (timer/counters, SPI, interrupt logic), general I/O peripherals, the asynchronous timer, the display controller, the ADC and the main oscillator.

An interrupt wakes the device. A reset always wakes it. If the chosen mode left the main oscillator running, the CPU clock comes back on the next edge. If the mode stopped the oscillator, the block first turns the oscillator back on. It then holds the CPU off while a start-up counter runs, and only after that reports the device ready again.

All enables are registered, so they change only on a clock edge.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: While reset is low, and in the active state, every clock-enable is 1, `wake_ready` is 1 and `mode_now` reads 7.
- R2: Sleep is entered on the edge that samples `sleep_strobe`=1 together with `sleep_en`=1 and a legal `mode_sel`. A strobe with `sleep_en`=0 leaves the block active.
- R3: The `mode_sel` codes 4, 5 and 7 are not legal. A strobe carrying one of them leaves the block active. The legal codes are 0 Idle, 1 ADC noise reduction, 2 Power-down, 3 Power-save and 6 Standby.
- R4: Idle (code 0) turns off only the CPU enable.
- R5: ADC noise reduction (code 1) keeps only the asynchronous timer, display, ADC and oscillator enables on.
- R6: Power-save (code 3) keeps only the asynchronous timer and display enables on.
- R7: Power-down (code 2) turns off every enable, including the oscillator.
- R8: Standby (code 6) keeps only the oscillator enable on.
- R9: In Idle, ADC noise reduction or Standby, an interrupt sampled at an edge returns the block to active at that same edge.
- R10: In Power-down or Power-save, an interrupt moves the block into a start-up phase. This phase lasts exactly `startup_cycles`+1 cycles. During it the oscillator enable is 1, the CPU enable is 0 and `wake_ready` is 0. Active therefore resumes at the (`startup_cycles`+2)-th edge, counting the edge that sampled the interrupt as the first.
- R11: A sleep strobe is ignored while asleep or starting up. An interrupt is ignored while active.
- R12: `startup_cycles` is captured at the wake edge. Changing it during the start-up phase does not change the phase length.
- R13: A reset during the start-up phase returns the block to active and clears the counter. The next slow wake runs the full start-up count.
- R14: While asleep or starting up, `mode_now` shows the code of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Sleep arm bit |
| sleep_strobe | input | 1 | One-cycle sleep request |
| mode_sel | input | 3 | Requested sleep mode code |
| startup_cycles | input | CNT_W | Oscillator start-up delay count |
| irq | input | 1 | Wake interrupt |
| ce_cpu | output | 1 | CPU clock enable |
| ce_mem | output | 1 | Data memory and core peripheral clock enable |
| ce_io | output | 1 | General I/O peripheral clock enable |
| ce_atimer | output | 1 | Asynchronous timer clock enable |
| ce_disp | output | 1 | Display controller clock enable |
| ce_adc | output | 1 | ADC clock enable |
| ce_osc | output | 1 | Main oscillator enable |
| wake_ready | output | 1 | High when active |
| mode_now | output | 3 | Current mode code, 7 when active |

## Verification
The bench builds the block with `CNT_W`=5. This puts the largest start-up count, 31, within a few dozen cycles, so the zero count, a small count and the full-scale count are all timed end to end. The same setting leaves room to reprogram the count during a start-up phase and to reset in the middle of one.

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_en,
  input  logic             sleep_strobe,
  input  logic [2:0]       mode_sel,
  input  logic [CNT_W-1:0] startup_cycles,
  input  logic             irq,
  output logic             ce_cpu,
  output logic             ce_mem,
  output logic             ce_io,
  output logic             ce_atimer,
  output logic             ce_disp,
  output logic             ce_adc,
  output logic             ce_osc,
  output logic             wake_ready,
  output logic [2:0]       mode_now
);

  localparam logic [2:0] M_IDLE  = 3'd0;
  localparam logic [2:0] M_ADCNR = 3'd1;
  localparam logic [2:0] M_PDOWN = 3'd2;
  localparam logic [2:0] M_PSAVE = 3'd3;
  localparam logic [2:0] M_STBY  = 3'd6;
  localparam logic [2:0] M_NONE  = 3'd7;
  localparam int         NDOM    = 7;

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_WARM} st_t;

  st_t              st, st_n;
  logic [2:0]       mode_q, mode_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [NDOM-1:0]  ce_q, ce_n;
  logic             rdy_q;
  logic [2:0]       mnow_q;

  // bit order {cpu, mem, io, atimer, disp, adc, osc}
  function automatic logic [NDOM-1:0] keep_mask(input logic [2:0] m);
    case (m)
      M_IDLE:  keep_mask = 7'b0111111;
      M_ADCNR: keep_mask = 7'b0001111;
      M_PSAVE: keep_mask = 7'b0001100;
      M_STBY:  keep_mask = 7'b0000001;
      default: keep_mask = 7'b0000000;
    endcase
  endfunction

  wire mode_ok  = mode_sel inside {M_IDLE, M_ADCNR, M_PDOWN, M_PSAVE, M_STBY};
  wire enter    = sleep_strobe && sleep_en && mode_ok;
  wire osc_kept = mode_q inside {M_IDLE, M_ADCNR, M_STBY};

  always_comb begin
    st_n   = st;
    mode_n = mode_q;
    cnt_n  = cnt;
    case (st)
      S_RUN:   if (enter) begin
                 st_n   = S_SLEEP;
                 mode_n = mode_sel;
               end
      S_SLEEP: if (irq) begin
                 if (osc_kept) st_n = S_RUN;
                 else begin
                   st_n  = S_WARM;
                   cnt_n = startup_cycles;
                 end
               end
      S_WARM:  if (cnt == '0) st_n = S_RUN;
               else cnt_n = cnt - 1'b1;
      default: st_n = S_RUN;
    endcase
  end

  always_comb begin
    if (st_n == S_RUN) ce_n = '1;
    else ce_n = keep_mask(mode_n) | {{(NDOM-1){1'b0}}, st_n == S_WARM};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      mode_q <= M_IDLE;
      cnt    <= '0;
      ce_q   <= '1;
      rdy_q  <= 1'b1;
      mnow_q <= M_NONE;
    end else begin
      st     <= st_n;
      mode_q <= mode_n;
      cnt    <= cnt_n;
      ce_q   <= ce_n;
      rdy_q  <= st_n == S_RUN;
      mnow_q <= (st_n == S_RUN) ? M_NONE : mode_n;
    end
  end

  assign {ce_cpu, ce_mem, ce_io, ce_atimer, ce_disp, ce_adc, ce_osc} = ce_q;
  assign wake_ready = rdy_q;
  assign mode_now   = mnow_q;

endmodule

// File: rtl/sleep_clkgate_ctrl_sva.sv
module sleep_clkgate_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_en,
  input logic       sleep_strobe,
  input logic [2:0] mode_sel,
  input logic       irq,
  input logic       ce_cpu,
  input logic       ce_mem,
  input logic       ce_io,
  input logic       ce_atimer,
  input logic       ce_disp,
  input logic       ce_adc,
  input logic       ce_osc,
  input logic       wake_ready,
  input logic [2:0] mode_now
);

  wire [6:0] ce = {ce_cpu, ce_mem, ce_io, ce_atimer, ce_disp, ce_adc, ce_osc};

  p_active_all_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ready |-> (ce == 7'h7F && mode_now == 3'd7));

  p_no_arm_no_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_ready && sleep_strobe && !sleep_en) |=> wake_ready);

  p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_ready && sleep_strobe && sleep_en && !(mode_sel inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}))
    |=> wake_ready);

  p_idle_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 3'd0) |-> (ce == 7'b0111111));

  p_adcnr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 3'd1) |-> (ce == 7'b0001111));

  p_psave_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 3'd3 && !ce_osc) |-> (ce == 7'b0001100));

  p_pdown_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 3'd2 && !ce_osc) |-> (ce == 7'b0000000));

  p_standby_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == 3'd6) |-> (ce == 7'b0000001));

  p_fast_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_now inside {3'd0, 3'd1, 3'd6}) && irq) |=> wake_ready);

  p_slow_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_now inside {3'd2, 3'd3}) && !ce_osc && irq) |=> (!wake_ready && ce_osc && !ce_cpu));

  p_stay_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_ready && !ce_osc && !irq) |=> (!wake_ready && $stable(mode_now)));

endmodule

bind sleep_clkgate_ctrl sleep_clkgate_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_strobe(sleep_strobe),
  .mode_sel(mode_sel), .irq(irq), .ce_cpu(ce_cpu), .ce_mem(ce_mem), .ce_io(ce_io),
  .ce_atimer(ce_atimer), .ce_disp(ce_disp), .ce_adc(ce_adc), .ce_osc(ce_osc),
  .wake_ready(wake_ready), .mode_now(mode_now)
);

// File: tb/sleep_clkgate_ctrl_bench.sv
module sleep_clkgate_ctrl_bench;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_en = 1'b0, sleep_strobe = 1'b0, irq = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic [CW-1:0] startup_cycles = '0;
  logic ce_cpu, ce_mem, ce_io, ce_atimer, ce_disp, ce_adc, ce_osc, wake_ready;
  logic [2:0] mode_now;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sleep_clkgate_ctrl #(.CNT_W(CW)) u_sleep_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_strobe(sleep_strobe),
    .mode_sel(mode_sel), .startup_cycles(startup_cycles), .irq(irq),
    .ce_cpu(ce_cpu), .ce_mem(ce_mem), .ce_io(ce_io), .ce_atimer(ce_atimer),
    .ce_disp(ce_disp), .ce_adc(ce_adc), .ce_osc(ce_osc),
    .wake_ready(wake_ready), .mode_now(mode_now));

  wire [6:0] ce = {ce_cpu, ce_mem, ce_io, ce_atimer, ce_disp, ce_adc, ce_osc};

  // reference: phase 0 active, 1 asleep, 2 oscillator start-up
  int ph = 0, mm = 0, left = 0;

  function automatic bit legal(int m);
    return m == 0 || m == 1 || m == 2 || m == 3 || m == 6;
  endfunction

  function automatic logic [6:0] expect_mask(int m);
    logic [6:0] v = 7'b0;
    if (m == 0) v = 7'b0111111;
    if (m == 1) begin v[3] = 1; v[2] = 1; v[1] = 1; v[0] = 1; end
    if (m == 3) begin v[3] = 1; v[2] = 1; end
    if (m == 6) v[0] = 1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ph = 0; mm = 0; left = 0; end
    else if (ph == 0) begin
      if (sleep_strobe && sleep_en && legal(int'(mode_sel))) begin ph = 1; mm = int'(mode_sel); end
    end else if (ph == 1) begin
      if (irq) begin
        if (mm == 2 || mm == 3) begin ph = 2; left = int'(startup_cycles); end
        else ph = 0;
      end
    end else begin
      if (left == 0) ph = 0; else left = left - 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [6:0] ev;
    ev = (ph == 0) ? 7'h7F : (expect_mask(mm) | ((ph == 2) ? 7'b1 : 7'b0));
    check(ce == ev, cur_req, int'(ce), int'(ev));
    check(wake_ready == (ph == 0), cur_req, int'(wake_ready), int'(ph == 0));
    check(int'(mode_now) == ((ph == 0) ? 7 : mm), cur_req, int'(mode_now), (ph == 0) ? 7 : mm);
  end

  task automatic strobe(input int m, input bit en);
    sleep_en = en; mode_sel = 3'(m); sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0;
  endtask

  task automatic wake_count(output int edges);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    edges = 1;
    while (!wake_ready && edges < 200) begin @(negedge clk); edges++; end
  endtask

  initial begin
    int n;
    int mlist[5] = '{0, 1, 3, 2, 6};
    int su[3] = '{0, 3, 31};
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(ce == 7'h7F && wake_ready && mode_now == 3'd7, "R1", int'(ce), 'h7F);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R11";
    irq = 1'b1; @(negedge clk); irq = 1'b0; @(negedge clk);
    check(wake_ready, "R11 irq while active", int'(wake_ready), 1);

    cur_req = "R2";
    strobe(0, 1'b0); @(negedge clk);
    check(wake_ready, "R2 strobe without enable", int'(wake_ready), 1);

    cur_req = "R3";
    foreach (su[i]) ;
    strobe(4, 1'b1); check(wake_ready, "R3 code 4", int'(wake_ready), 1);
    strobe(5, 1'b1); check(wake_ready, "R3 code 5", int'(wake_ready), 1);
    strobe(7, 1'b1); check(wake_ready, "R3 code 7", int'(wake_ready), 1);

    foreach (mlist[i]) begin
      int m = mlist[i];
      cur_req = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 3) ? "R6" : (m == 2) ? "R7" : "R8";
      strobe(m, 1'b1);
      check(!wake_ready, "R2 entry", int'(wake_ready), 0);
      check(int'(mode_now) == m, "R14 mode report", int'(mode_now), m);
      check(ce == expect_mask(m), cur_req, int'(ce), int'(expect_mask(m)));
      strobe(6 - (m == 6 ? 6 : 0), 1'b1);
      check(int'(mode_now) == m && !wake_ready, "R11 strobe while asleep", int'(mode_now), m);
      repeat (2) @(negedge clk);
      if (m == 2 || m == 3) begin
        foreach (su[k]) begin
          cur_req = "R10";
          startup_cycles = CW'(su[k]);
          wake_count(n);
          check(n == su[k] + 2, "R10 start-up length", n, su[k] + 2);
          strobe(m, 1'b1);
        end
        cur_req = "R12";
        startup_cycles = CW'(3);
        irq = 1'b1; @(negedge clk); irq = 1'b0;
        startup_cycles = CW'(20);
        n = 1;
        while (!wake_ready && n < 200) begin @(negedge clk); n++; end
        check(n == 5, "R12 count captured at wake", n, 5);
      end else begin
        cur_req = "R9";
        wake_count(n);
        check(n == 1, "R9 fast wake", n, 1);
      end
      @(negedge clk);
    end

    cur_req = "R13";
    startup_cycles = CW'(20);
    strobe(2, 1'b1);
    irq = 1'b1; @(negedge clk); irq = 1'b0;
    repeat (5) @(negedge clk);
    check(!wake_ready && ce_osc, "R13 in start-up", int'(wake_ready), 0);
    rst_n = 1'b0; #1;
    check(ce == 7'h7F && wake_ready && mode_now == 3'd7, "R13 reset mid start-up", int'(ce), 'h7F);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    strobe(2, 1'b1);
    wake_count(n);
    check(n == 22, "R13 full count after reset", n, 22);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule